// File: doc/BRIEF.md
# Battery-Backed SRAM Access Port

This block is a clocked model of a byte-wide static memory port that is normally driven asynchronously. Three active-low pins control it: chip select, output enable and write enable. On every clock it samples them, decodes the access mode, and decides whether the 8-bit data bus is driven with stored data or left high-impedance. The bus is split into an input byte, an output byte and an output-enable flag, which a pad ring combines into one bidirectional pin set. Writes go into an internal byte array, which reset does not clear.

A write window is tracked across clock edges. It opens on the first sampled edge where chip select and write enable are both low. It closes on the first edge where either of them is high again. The data byte present at the closing edge is stored at the address sampled when the window opened. Two timing checks run alongside the window. One flags a cycle that starts before the post-write recovery interval has elapsed. The other flags an address that moves while the window is open. A power-fail input from a supply supervisor overrides every pin state. While it is high, the port is deselected and all accesses are blocked.

Top module: `bbram_port`

## Requirements
- R1: With chipSelN high and powerFail low, mode reads 0 (deselect) and dqOe is 0, whatever outEnN and writeEnN are.
- R2: With chipSelN low, outEnN low, writeEnN high and powerFail low, mode reads 1 (read), dqOe is 1 and dqOut is the byte stored at addr, combinationally.
- R3: With chipSelN low, outEnN high, writeEnN high and powerFail low, mode reads 2 (read with bus released) and dqOe is 0.
- R4: With chipSelN low, writeEnN low and powerFail low, mode reads 3 (write) and dqOe is 0 whatever outEnN is. A bus driven by a read with outEnN low is released as soon as writeEnN falls.
- R5: A write window opens at the first clock edge sampling chipSelN and writeEnN both low. It closes at the first later edge sampling either one high, whichever pin is released first. At that closing edge, dqIn is stored at the address sampled at the opening edge, and the byte reads back from the following cycle on.
- R6: For the REC_CYCLES clock edges after a closing edge, chipSelN and writeEnN must both be sampled high. An edge in that interval that samples either one low makes recoveryViol 1 for exactly one cycle after it. A write whose recovery interval is met raises no flag.
- R7: An edge that samples an open window still active with addr different from the addr of the previous edge makes addrViol 1 for one cycle after that edge. The byte is still stored at the address sampled when the window opened.
- R8: While powerFail is high, mode reads 0, dqOe is 0 and no byte is stored. A window open when powerFail rises is abandoned without storing anything.
- R9: Reset (rstN low) clears recoveryViol, addrViol, any open window and the recovery interval, but keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSelN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output enable |
| writeEnN | input | 1 | Active-low write enable |
| powerFail | input | 1 | Supervisor inhibit, high blocks all access |
| addr | input | ADDR_W | Byte address |
| dqIn | input | 8 | Data bus as seen at the pins |
| dqOut | output | 8 | Byte to drive onto the bus |
| dqOe | output | 1 | Bus driver enable, 0 means high-impedance |
| mode | output | 2 | Decoded mode: 0 deselect, 1 read, 2 read released, 3 write |
| recoveryViol | output | 1 | One-cycle pulse on a recovery interval violation |
| addrViol | output | 1 | One-cycle pulse on an address change inside a write window |

## Verification
The hardest case to reach is a window that power-fail abandons. The pins must still show a valid write when the inhibit rises. The stimulus opens a window to an address that already holds a known byte, raises powerFail for two cycles while chip select and write enable stay low, releases everything, and then reads the address back to show the old byte survived. The recovery check is reached the same way. A write is closed, and chip select drops on the very next edge, so the read and the flag are seen together.

// File: rtl/bbram_pkg.sv
package bbram_pkg;

  typedef enum logic [1:0] {
    MODE_DESEL    = 2'd0,
    MODE_READ     = 2'd1,
    MODE_READ_HIZ = 2'd2,
    MODE_WRITE    = 2'd3
  } portMode_t;

  typedef struct packed {
    logic latchAddr;  // window opens: capture address
    logic commit;     // window closes cleanly: store data in
    logic driveBus;   // read with outputs enabled
  } strobes_t;

endpackage

// File: rtl/bbram_ctrl.sv
module bbram_ctrl
  import bbram_pkg::*;
#(
  parameter int REC_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSelN,
  input  logic      outEnN,
  input  logic      writeEnN,
  input  logic      powerFail,
  input  logic      addrMoved,
  output strobes_t  strobes,
  output portMode_t mode,
  output logic      recoveryViol,
  output logic      addrViol
);

  localparam int REC_W = (REC_CYCLES < 1) ? 1 : $clog2(REC_CYCLES + 1);

  logic             winOpen;
  logic [REC_W-1:0] recCnt;
  logic             writeActive;

  assign writeActive = !powerFail && !chipSelN && !writeEnN;

  always_comb begin
    if (powerFail || chipSelN) mode = MODE_DESEL;
    else if (!writeEnN)        mode = MODE_WRITE;
    else if (!outEnN)          mode = MODE_READ;
    else                       mode = MODE_READ_HIZ;
  end

  always_comb begin
    strobes.latchAddr = writeActive && !winOpen;
    strobes.commit    = winOpen && !powerFail && (chipSelN || writeEnN);
    strobes.driveBus  = (mode == MODE_READ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winOpen      <= 1'b0;
      recCnt       <= '0;
      recoveryViol <= 1'b0;
      addrViol     <= 1'b0;
    end else begin
      winOpen      <= writeActive;
      addrViol     <= winOpen && writeActive && addrMoved;
      recoveryViol <= 1'b0;
      if (powerFail) begin
        recCnt <= '0;
      end else if (strobes.commit) begin
        recCnt <= REC_W'(REC_CYCLES);
      end else if (recCnt != '0) begin
        if (chipSelN && writeEnN) begin
          recCnt <= recCnt - 1'b1;
        end else begin
          recCnt       <= '0;
          recoveryViol <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bbram_datapath.sv
module bbram_datapath
  import bbram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  input  strobes_t          strobes,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              addrMoved
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [ADDR_W-1:0] winAddr;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk) begin
    lastAddr <= addr;
    if (strobes.latchAddr) winAddr <= addr;
    if (strobes.commit) memArray[winAddr] <= dqIn;
  end

  assign addrMoved = (addr != lastAddr);
  assign dqOe      = strobes.driveBus;
  assign dqOut     = strobes.driveBus ? memArray[addr] : '0;

endmodule

// File: rtl/bbram_port.sv
module bbram_port
  import bbram_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REC_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              outEnN,
  input  logic              writeEnN,
  input  logic              powerFail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dqIn,
  output logic [7:0]        dqOut,
  output logic              dqOe,
  output logic [1:0]        mode,
  output logic              recoveryViol,
  output logic              addrViol
);

  strobes_t  strobes;
  portMode_t modeInt;
  logic      addrMoved;

  bbram_ctrl #(.REC_CYCLES(REC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .outEnN(outEnN),
    .writeEnN(writeEnN), .powerFail(powerFail), .addrMoved(addrMoved),
    .strobes(strobes), .mode(modeInt), .recoveryViol(recoveryViol),
    .addrViol(addrViol)
  );

  bbram_datapath #(.ADDR_W(ADDR_W), .DATA_W(8)) u_dp (
    .clk(clk), .addr(addr), .dqIn(dqIn), .strobes(strobes),
    .dqOut(dqOut), .dqOe(dqOe), .addrMoved(addrMoved)
  );

  assign mode = modeInt;

endmodule

// File: rtl/bbram_port_chk.sv
module bbram_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       chipSelN,
  input logic       outEnN,
  input logic       writeEnN,
  input logic       powerFail,
  input logic       dqOe,
  input logic [1:0] mode,
  input logic       recoveryViol,
  input logic       addrViol
);

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN && !powerFail) |-> (!dqOe && mode == 2'd0));  // R1

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !outEnN && writeEnN && !powerFail) |-> (dqOe && mode == 2'd1));  // R2

  AST_HIZ_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && outEnN && writeEnN && !powerFail) |-> (!dqOe && mode == 2'd2));  // R3

  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !writeEnN && !powerFail) |-> (!dqOe && mode == 2'd3));  // R4

  AST_REC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    recoveryViol |=> !recoveryViol);  // R6

  AST_ADDRV_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    addrViol |-> $past(!chipSelN && !writeEnN && !powerFail));  // R7

  AST_PF_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> (!dqOe && mode == 2'd0));  // R8

endmodule

bind bbram_port bbram_port_chk u_chk (
  .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .outEnN(outEnN),
  .writeEnN(writeEnN), .powerFail(powerFail), .dqOe(dqOe), .mode(mode),
  .recoveryViol(recoveryViol), .addrViol(addrViol)
);

// File: tb/bbram_port_bench.sv
module bbram_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSelN = 1'b1, outEnN = 1'b1, writeEnN = 1'b1, powerFail = 1'b0;
  logic [7:0] addr = '0, dqIn = '0;
  logic [7:0] dqOut;
  logic       dqOe;
  logic [1:0] mode;
  logic       recoveryViol, addrViol;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bbram_port #(.ADDR_W(8), .REC_CYCLES(2)) u_bbram_port (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .outEnN(outEnN),
    .writeEnN(writeEnN), .powerFail(powerFail), .addr(addr), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .mode(mode), .recoveryViol(recoveryViol),
    .addrViol(addrViol)
  );

  // {ceN,oeN,weN,pf}, addr, din, expOe, expDout, expMode
  localparam int NVEC = 26;
  localparam logic [30:0] VEC [NVEC] = '{
    {4'b1110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},  // R1 idle
    {4'b0100, 8'h10, 8'hA5, 1'b0, 8'h00, 2'd3},  // R5 open
    {4'b0100, 8'h10, 8'hA5, 1'b0, 8'h00, 2'd3},
    {4'b1110, 8'h10, 8'hA5, 1'b0, 8'h00, 2'd0},  // R5 close by select
    {4'b1110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b1110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b0010, 8'h10, 8'h00, 1'b1, 8'hA5, 2'd1},  // R2 readback
    {4'b0010, 8'h10, 8'h00, 1'b1, 8'hA5, 2'd1},
    {4'b0000, 8'h10, 8'h3C, 1'b0, 8'h00, 2'd3},  // R4 bus released
    {4'b1010, 8'h10, 8'h3C, 1'b0, 8'h00, 2'd0},
    {4'b1110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b1110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b0010, 8'h10, 8'h00, 1'b1, 8'h3C, 2'd1},  // R5 overwrite
    {4'b0110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd2},  // R3
    {4'b0011, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},  // R8 read blocked
    {4'b0001, 8'h10, 8'hFF, 1'b0, 8'h00, 2'd0},  // R8 write blocked
    {4'b0001, 8'h10, 8'hFF, 1'b0, 8'h00, 2'd0},
    {4'b1110, 8'h10, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b0010, 8'h10, 8'h00, 1'b1, 8'h3C, 2'd1},  // R8 no store
    {4'b1100, 8'h30, 8'h00, 1'b0, 8'h00, 2'd0},  // R1 we low only
    {4'b0100, 8'h30, 8'h77, 1'b0, 8'h00, 2'd3},
    {4'b0110, 8'h30, 8'h77, 1'b0, 8'h00, 2'd2},  // R5 close by write enable
    {4'b1110, 8'h30, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b1110, 8'h30, 8'h00, 1'b0, 8'h00, 2'd0},
    {4'b0010, 8'h30, 8'h00, 1'b1, 8'h77, 2'd1},
    {4'b0010, 8'h10, 8'h00, 1'b1, 8'h3C, 2'd1}
  };

  task automatic step(input logic [3:0] pins, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    {chipSelN, outEnN, writeEnN, powerFail} = pins;
    addr = a;
    dqIn = d;
    #5;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(posedge clk);
    #5;
    check("R9 reset flags", {30'd0, recoveryViol, addrViol}, 32'd0);
    check("R1 reset mode", {29'd0, dqOe, mode}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][30:27], VEC[i][26:19], VEC[i][18:11]);
      check($sformatf("R1-row%0d oe/mode/viol", i),
            {27'd0, dqOe, mode, recoveryViol, addrViol},
            {27'd0, VEC[i][10], VEC[i][1:0], 2'b00});
      if (VEC[i][10]) check($sformatf("R2 row%0d data", i), {24'd0, dqOut}, {24'd0, VEC[i][9:2]});
    end

    // R6: recovery violated by a read on the first edge after closing
    step(4'b1110, 8'h40, 8'h00);
    step(4'b0100, 8'h40, 8'h5A);
    step(4'b1110, 8'h40, 8'h5A);
    step(4'b0010, 8'h40, 8'h00);
    check("R5 data after close", {24'd0, dqOut}, 32'h5A);
    check("R6 no flag yet", {31'd0, recoveryViol}, 32'd0);
    step(4'b1110, 8'h40, 8'h00);
    check("R6 flag raised", {31'd0, recoveryViol}, 32'd1);
    step(4'b1110, 8'h40, 8'h00);
    check("R6 flag one cycle", {31'd0, recoveryViol}, 32'd0);
    step(4'b1110, 8'h40, 8'h00);

    // R7: address moves inside a window
    step(4'b0100, 8'h50, 8'h00);
    step(4'b0100, 8'h51, 8'h00);
    check("R7 no flag before edge", {31'd0, addrViol}, 32'd0);
    step(4'b0100, 8'h51, 8'h00);
    check("R7 flag raised", {31'd0, addrViol}, 32'd1);
    step(4'b1110, 8'h51, 8'h9C);
    check("R7 flag one cycle", {31'd0, addrViol}, 32'd0);
    step(4'b1110, 8'h00, 8'h00);
    step(4'b1110, 8'h00, 8'h00);
    step(4'b0010, 8'h50, 8'h00);
    check("R7 stored at opening address", {24'd0, dqOut}, 32'h9C);
    check("R6 met interval no flag", {31'd0, recoveryViol}, 32'd0);

    // R8: window abandoned by power fail
    step(4'b1110, 8'h60, 8'h00);
    step(4'b0100, 8'h60, 8'h11);
    step(4'b1110, 8'h60, 8'h11);
    step(4'b1110, 8'h60, 8'h00);
    step(4'b1110, 8'h60, 8'h00);
    step(4'b0100, 8'h60, 8'h22);
    step(4'b0101, 8'h60, 8'h22);
    check("R8 mode forced deselect", {29'd0, dqOe, mode}, 32'd0);
    step(4'b0101, 8'h60, 8'h22);
    step(4'b1110, 8'h60, 8'h22);
    step(4'b1110, 8'h60, 8'h00);
    step(4'b1110, 8'h60, 8'h00);
    step(4'b0010, 8'h60, 8'h00);
    check("R8 old byte kept", {24'd0, dqOut}, 32'h11);
    check("R6 no flag after abort", {31'd0, recoveryViol}, 32'd0);

    // R9: reset keeps array contents
    step(4'b1110, 8'h00, 8'h00);
    rstN = 1'b0;
    step(4'b1110, 8'h00, 8'h00);
    step(4'b1110, 8'h00, 8'h00);
    rstN = 1'b1;
    step(4'b0010, 8'h60, 8'h00);
    check("R9 data kept at 60", {24'd0, dqOut}, 32'h11);
    step(4'b0010, 8'h30, 8'h00);
    check("R9 data kept at 30", {24'd0, dqOut}, 32'h77);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule